// File: doc/BRIEF.md
# External Interrupt Bank Controller

This block collects thirty-two external interrupt lines, arranged as four banks of eight. Each line can be set to trigger on a rising edge, a falling edge, either edge, a low level or a high level. It has a mask bit and a pending bit. Every line is first brought into the clock domain by a two-stage synchronizer. The chosen trigger condition then sets the line's pending bit.

The lower sixteen lines each drive a dedicated interrupt output. The upper sixteen share a single combined output. An output is high when its pending bit is set and its mask bit is clear. Software reaches the trigger fields, the masks and the pending bits of each bank through a small word-addressed register port. Pending bits are cleared by writing ones.

Top module: `extint_bank_ctrl`

## Requirements
- R1: Line p belongs to bank p>>3 at bit p&7. The registers sit at byte offsets 0x00+4*bank (trigger), 0x10+4*bank (mask) and 0x20+4*bank (pending). Offsets 0x30..0x3C and any address with bits [1:0] nonzero read as zero and ignore writes. `rd_data` shows the register addressed on the previous clock edge.
- R2: The trigger register holds one 3-bit field per bit b, at bits [4b+2:4b]. Bit 4b+3 always reads 0. Each field resets to 3'b011, so the register reads 0x33333333 after reset.
- R3: Field 3'b011 triggers on a rising edge, 3'b010 on a falling edge, and any value 1xx on both edges. A level change on a pin sets pending on the third clock edge after the change, and the output follows one edge later. An edge of the wrong direction sets nothing.
- R4: Field 3'b000 triggers on a low level and 3'b001 on a high level. While the level persists, pending is set again every cycle. A clear that arrives in the same cycle as a set loses, so pending only stays cleared once the level has gone.
- R5: Mask bit 1 masks the line and 0 enables it. All mask bits reset to 1. Masking hides the line from the outputs, but pending is still set, and masking never clears pending.
- R6: Pending resets to 0. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R7: `irq_direct[p]` for p<16 is a registered copy of (pending[p] AND NOT mask[p]). It lags the register state by one edge.
- R8: `irq_combined` is a registered OR, over lines 16..31, of (pending AND NOT mask). It lags the register state by one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Asynchronous external interrupt lines |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the address of the previous cycle |
| irq_direct | output | 16 | Per-line interrupt outputs for lines 0..15 |
| irq_combined | output | 1 | Shared interrupt output for lines 16..31 |

## Verification
A pending bit that is stuck or lost shows up one edge later on the matching direct line or on the combined line. For a lower line this happens only when the line is unmasked. For the upper lines it is hidden unless no other upper line is active. A trigger field decoded to the wrong type is only exposed when the pin moves. It then appears four edges after the pin change, as an output that is missing or comes from the wrong direction. A level trigger that re-sets too weakly shows as a cleared bit while the level is still held. Masked state is reached only through a pending read-back one cycle after the address.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [2:0] {
    TRIG_LOW  = 3'b000,
    TRIG_HIGH = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_RISE = 3'b011,
    TRIG_BOTH = 3'b100
  } trig_e;

  localparam logic [2:0] TRIG_RESET = TRIG_RISE;

  // True when the programmed trigger condition is met this cycle.
  function automatic logic trig_hit(input logic [2:0] fld, input logic cur, input logic prev);
    logic hit;
    if (fld[2]) hit = cur ^ prev;
    else begin
      unique case (fld[1:0])
        2'b00:   hit = ~cur;
        2'b01:   hit = cur;
        2'b10:   hit = ~cur & prev;
        default: hit = cur & ~prev;
      endcase
    end
    return hit;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   level,
  input  logic [3*PINS-1:0] fields,
  output logic [PINS-1:0]   hit
);
  logic [PINS-1:0] level_d;

  always_ff @(posedge clk) begin
    if (rst) level_d <= '0;
    else     level_d <= level;
  end

  for (genvar b = 0; b < PINS; b++) begin : g_pin
    assign hit[b] = trig_hit(fields[3*b +: 3], level[b], level_d[b]);
  end
endmodule

// File: rtl/extint_bank_regs.sv
module extint_bank_regs
  import extint_pkg::*;
#(
  parameter  int PINS = 8,
  localparam int DW   = 4 * PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              mask_we,
  input  logic              pend_we,
  input  logic [DW-1:0]     wdata,
  input  logic [PINS-1:0]   hit,
  output logic [DW-1:0]     cfg_q,
  output logic [3*PINS-1:0] fields,
  output logic [PINS-1:0]   mask_q,
  output logic [PINS-1:0]   pend_q
);
  logic [PINS-1:0] clr;

  for (genvar b = 0; b < PINS; b++) begin : g_fld
    logic [2:0] fld;
    always_ff @(posedge clk) begin
      if (rst)         fld <= TRIG_RESET;
      else if (cfg_we) fld <= wdata[4*b +: 3];
    end
    assign fields[3*b +: 3] = fld;
    assign cfg_q[4*b +: 4]  = {1'b0, fld};
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '1;
    else if (mask_we) mask_q <= wdata[PINS-1:0];
  end

  assign clr = pend_we ? wdata[PINS-1:0] : '0;

  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr) | hit;
  end
endmodule

// File: rtl/extint_bank_ctrl.sv
module extint_bank_ctrl #(
  parameter  int NUM_BANKS     = 4,
  parameter  int PINS_PER_BANK = 8,
  parameter  int DIRECT_PINS   = 16,
  localparam int NUM_PINS      = NUM_BANKS * PINS_PER_BANK,
  localparam int DATA_W        = 4 * PINS_PER_BANK,
  localparam int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W        = BANK_W + 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_PINS-1:0]    pin_in,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      rd_data,
  output logic [DIRECT_PINS-1:0] irq_direct,
  output logic                   irq_combined
);
  localparam int SHARED = NUM_PINS - DIRECT_PINS;

  logic [1:0]        region;
  logic [BANK_W-1:0] bank_sel;
  logic              aligned;

  logic [NUM_BANKS-1:0][DATA_W-1:0] cfg_rd;
  logic [NUM_PINS-1:0]              mask_all;
  logic [NUM_PINS-1:0]              pend_all;

  assign region   = bus_addr[ADDR_W-1 -: 2];
  assign bank_sel = bus_addr[2 +: BANK_W];
  assign aligned  = (bus_addr[1:0] == 2'b00);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic [PINS_PER_BANK-1:0]   sync_lv;
    logic [PINS_PER_BANK-1:0]   hit;
    logic [3*PINS_PER_BANK-1:0] fields;
    logic                       sel;

    assign sel = bus_wr && aligned && (bank_sel == BANK_W'(k));

    extint_sync #(.WIDTH(PINS_PER_BANK)) sync_i (
      .clk(clk), .rst(rst),
      .async_in(pin_in[k*PINS_PER_BANK +: PINS_PER_BANK]),
      .sync_out(sync_lv)
    );

    extint_detect #(.PINS(PINS_PER_BANK)) det_i (
      .clk(clk), .rst(rst), .level(sync_lv), .fields(fields), .hit(hit)
    );

    extint_bank_regs #(.PINS(PINS_PER_BANK)) regs_i (
      .clk(clk), .rst(rst),
      .cfg_we(sel && region == 2'd0),
      .mask_we(sel && region == 2'd1),
      .pend_we(sel && region == 2'd2),
      .wdata(bus_wdata), .hit(hit),
      .cfg_q(cfg_rd[k]), .fields(fields),
      .mask_q(mask_all[k*PINS_PER_BANK +: PINS_PER_BANK]),
      .pend_q(pend_all[k*PINS_PER_BANK +: PINS_PER_BANK])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (!aligned) rd_data <= '0;
    else begin
      unique case (region)
        2'd0:    rd_data <= cfg_rd[bank_sel];
        2'd1:    rd_data <= DATA_W'(mask_all[bank_sel*PINS_PER_BANK +: PINS_PER_BANK]);
        2'd2:    rd_data <= DATA_W'(pend_all[bank_sel*PINS_PER_BANK +: PINS_PER_BANK]);
        default: rd_data <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_direct   <= '0;
      irq_combined <= 1'b0;
    end else begin
      irq_direct   <= pend_all[DIRECT_PINS-1:0] & ~mask_all[DIRECT_PINS-1:0];
      irq_combined <= |(pend_all[NUM_PINS-1 -: SHARED] & ~mask_all[NUM_PINS-1 -: SHARED]);
    end
  end
endmodule

// File: rtl/extint_bank_ctrl_chk.sv
module extint_bank_ctrl_chk #(
  parameter int NUM_BANKS     = 4,
  parameter int PINS_PER_BANK = 8,
  parameter int DIRECT_PINS   = 16,
  parameter int ADDR_W        = 6
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic [ADDR_W-1:0]                    bus_addr,
  input logic                                 bus_wr,
  input logic [PINS_PER_BANK-1:0]             wr_low,
  input logic [4*PINS_PER_BANK-1:0]           rd_data,
  input logic [DIRECT_PINS-1:0]               irq_direct,
  input logic                                 irq_combined,
  input logic [NUM_BANKS*PINS_PER_BANK-1:0]   pend_all,
  input logic [NUM_BANKS*PINS_PER_BANK-1:0]   mask_all
);
  localparam int NP = NUM_BANKS * PINS_PER_BANK;
  localparam int DW = 4 * PINS_PER_BANK;
  localparam logic [DW-1:0] NIB_HI = {PINS_PER_BANK{4'b1000}};

  logic [NP-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (bus_wr && bus_addr[1:0] == 2'b00 && bus_addr[ADDR_W-1 -: 2] == 2'd2 &&
          int'(bus_addr[ADDR_W-3:2]) == k)
        clr_vec[k*PINS_PER_BANK +: PINS_PER_BANK] = wr_low;
    end
  end

  assert_cfg_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[ADDR_W-1 -: 2] == 2'd0) |=> ((rd_data & NIB_HI) == '0));

  assert_mask_reset_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_all == '1));

  assert_clear_only_by_write_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(pend_all) & ~pend_all) & ~$past(clr_vec)) == '0));

  assert_direct_follow_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_direct == $past(pend_all[DIRECT_PINS-1:0] & ~mask_all[DIRECT_PINS-1:0])));

  assert_combined_follow_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_combined == $past(|(pend_all[NP-1:DIRECT_PINS] & ~mask_all[NP-1:DIRECT_PINS]))));
endmodule

bind extint_bank_ctrl extint_bank_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .PINS_PER_BANK(PINS_PER_BANK),
  .DIRECT_PINS(DIRECT_PINS), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .wr_low(bus_wdata[PINS_PER_BANK-1:0]), .rd_data(rd_data),
  .irq_direct(irq_direct), .irq_combined(irq_combined),
  .pend_all(pend_all), .mask_all(mask_all)
);

// File: tb/extint_bank_ctrl_tb_top.sv
module extint_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic [15:0] irq_direct;
  logic        irq_combined;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    string       req;
    bit          is_read;
    logic [31:0] exp;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  extint_bank_ctrl dut_i (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .irq_direct(irq_direct),
    .irq_combined(irq_combined)
  );

  // Monitor: pops expected items and compares them with the ports.
  initial begin
    forever begin
      exp_t it;
      logic [31:0] act;
      wait (sb_q.size() != 0);
      it  = sb_q.pop_front();
      act = it.is_read ? rd_data : {15'b0, irq_combined, irq_direct};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s %s: actual=%h expected=%h", it.req,
                 it.is_read ? "read" : "irq", act, it.exp);
      end
    end
  end

  task automatic push(input string r, input bit rd, input logic [31:0] e);
    exp_t it;
    it.req = r; it.is_read = rd; it.exp = e;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic chk_out(input string r, input logic [15:0] d, input logic c);
    push(r, 1'b0, {15'b0, c, d});
  endtask

  task automatic chk_rd(input string r, input logic [5:0] a, input logic [31:0] e);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    push(r, 1'b1, e);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_pin();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_out("R7", 16'h0, 1'b0);
    chk_rd("R2", 6'h00, 32'h33333333);
    chk_rd("R5", 6'h10, 32'h000000FF);
    chk_rd("R6", 6'h20, 32'h0);
    chk_rd("R1", 6'h34, 32'h0);

    // Rising edge on line 3
    wr(6'h10, 32'h0);
    @(negedge clk); pin_in[3] = 1'b1; wait_pin();
    chk_out("R3", 16'h0008, 1'b0);
    chk_rd("R1", 6'h20, 32'h08);
    chk_rd("R1", 6'h21, 32'h0);
    wr(6'h20, 32'hF7);
    chk_rd("R6", 6'h20, 32'h08);
    wr(6'h20, 32'h08); @(negedge clk);
    chk_out("R6", 16'h0, 1'b0);
    pin_in[3] = 1'b0; wait_pin();
    chk_out("R3", 16'h0, 1'b0);

    // Falling edge on line 3
    wr(6'h00, 32'h33332333);
    chk_rd("R2", 6'h00, 32'h33332333);
    pin_in[3] = 1'b1; wait_pin();
    chk_out("R3", 16'h0, 1'b0);
    pin_in[3] = 1'b0; wait_pin();
    chk_out("R3", 16'h0008, 1'b0);
    wr(6'h20, 32'h08); @(negedge clk);

    // Both edges on line 9
    wr(6'h04, 32'h33333343);
    wr(6'h14, 32'h0);
    pin_in[9] = 1'b1; wait_pin();
    chk_out("R3", 16'h0200, 1'b0);
    wr(6'h24, 32'h02); @(negedge clk);
    chk_out("R6", 16'h0, 1'b0);
    pin_in[9] = 1'b0; wait_pin();
    chk_out("R3", 16'h0200, 1'b0);
    wr(6'h24, 32'h02); @(negedge clk);

    // High level on line 12: clear loses while level held
    wr(6'h04, 32'h33313343);
    pin_in[12] = 1'b1; wait_pin();
    chk_out("R4", 16'h1000, 1'b0);
    wr(6'h24, 32'h10); repeat (2) @(negedge clk);
    chk_out("R4", 16'h1000, 1'b0);
    chk_rd("R4", 6'h24, 32'h10);
    pin_in[12] = 1'b0; wait_pin();
    wr(6'h24, 32'h10); @(negedge clk);
    chk_out("R4", 16'h0, 1'b0);

    // Low level on line 20 while masked
    wr(6'h08, 32'h33303333);
    repeat (2) @(negedge clk);
    chk_out("R5", 16'h0, 1'b0);
    chk_rd("R4", 6'h28, 32'h10);
    wr(6'h18, 32'h0); @(negedge clk);
    chk_out("R8", 16'h0, 1'b1);
    pin_in[20] = 1'b1; wait_pin();
    wr(6'h28, 32'h10); @(negedge clk);
    chk_out("R8", 16'h0, 1'b0);

    // Line 31 on the combined output, masking keeps pending
    wr(6'h1C, 32'h0);
    pin_in[31] = 1'b1; wait_pin();
    chk_out("R8", 16'h0, 1'b1);
    wr(6'h1C, 32'h80); @(negedge clk);
    chk_out("R5", 16'h0, 1'b0);
    chk_rd("R5", 6'h2C, 32'h80);
    wr(6'h1C, 32'h0); @(negedge clk);
    chk_out("R8", 16'h0, 1'b1);
    wr(6'h2C, 32'h80); @(negedge clk);
    chk_out("R6", 16'h0, 1'b0);

    // Masked lower line 5, then unmask
    wr(6'h10, 32'h20);
    pin_in[5] = 1'b1; wait_pin();
    chk_out("R5", 16'h0, 1'b0);
    wr(6'h10, 32'h0); @(negedge clk);
    chk_out("R7", 16'h0020, 1'b0);
    wr(6'h20, 32'h20); @(negedge clk);

    // Lines 0 and 15 together
    pin_in[0] = 1'b1; pin_in[15] = 1'b1; wait_pin();
    chk_out("R7", 16'h8001, 1'b0);

    // Spare nibble bits of the trigger register
    wr(6'h0C, 32'hFFFFFFFF);
    chk_rd("R2", 6'h0C, 32'h77777777);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule